// File: doc/BRIEF.md
# Write-Only Command and Key-Push Register Block

This block is an APB slave with two write-only locations and one read-only status word. Writing to the command location does not store anything. Each command bit written as 1 creates a strobe that is high for exactly one cycle, during the access cycle of that write. The strobes start, abort or flush a small engine and its word store. Writing to the data location pushes the whole bus word into an internal first-in first-out key store. A consumer drains that store through a pop/valid/data interface.

Reads of the two write-only locations never return what was written. A build-time parameter selects the read policy: the read either returns zero with no error, or completes with PSLVERR set. The status location reports three things: the engine run flag, a sticky overflow flag and the number of words held in the store. Every transfer completes in its first access cycle. Any access to an unmapped offset is flagged as an error.

Top module: `wocmd_regblk`

## Requirements
- R1: After a synchronous active-high reset, `engine_run`, `key_valid` and `store_overflow` are 0, the store is empty, and an idle bus shows PRDATA = 0 and PSLVERR = 0.
- R2: PREADY is always 1, so every transfer finishes in its first access cycle.
- R3: A write to offset 0x10 with bit 0 set raises `start_pulse` during the access cycle only. It is low in the setup cycle and low in the next cycle. `engine_run` is 1 from the next cycle onward, and it rises only after such a write.
- R4: A write to offset 0x10 with bit 1 set raises `abort_pulse` for the access cycle and clears `engine_run` on the next cycle. When bits 0 and 1 are written together, abort wins and the run flag ends low.
- R5: A write to offset 0x10 with bit 2 set raises `flush_pulse` for the access cycle and empties the store by the next cycle. When bits 0, 1 and 2 are written together, the store is emptied and the run flag ends low.
- R6: A write to offset 0x10 with bits 0 to 2 all clear, or any read, produces no strobe and leaves `engine_run` unchanged.
- R7: Each write to offset 0x14 pushes the full 32-bit PWDATA into the store. `key_data` shows the oldest word while `key_valid` is 1, and the words leave in push order, one per cycle with `key_pop` high.
- R8: The store holds 8 words. A push that arrives while the store is full and no pop happens in the same cycle is dropped. The dropped push sets `store_overflow`, which stays set until reset.
- R9: A read of offset 0x10 or 0x14 returns PRDATA = 0 and never the written data. With the zero policy (STRICT_RD = 0) PSLVERR is 0. With the strict policy (STRICT_RD = 1) PSLVERR is 1.
- R10: A read of offset 0x18 returns the run flag in bit 0, the overflow flag in bit 1 and the store count in bits 11:8, with all other bits 0. A write to 0x18 completes without error and changes nothing.
- R11: An access to any other offset sets PSLVERR and has no effect on strobes, run flag or store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Error response |
| start_pulse | output | 1 | One-cycle start strobe |
| abort_pulse | output | 1 | One-cycle abort strobe |
| flush_pulse | output | 1 | One-cycle flush strobe |
| engine_run | output | 1 | Engine run flag |
| key_data | output | DATA_W | Oldest stored word |
| key_valid | output | 1 | Store not empty |
| key_pop | input | 1 | Consume the oldest word |
| store_overflow | output | 1 | Sticky dropped-push flag |

## Verification
The strobes, PRDATA and PSLVERR are combinational on the access cycle. The bench therefore samples them 1 ns after the negative edge that opens the access phase. It also samples the setup cycle, to prove that no strobe is early. The run flag, the store count and the overflow flag change on the rising edge that ends the access phase. They are checked at the next negative edge, or through a later status read. Each popped word is compared against a scoreboard queue just after `key_pop` is raised, before the rising edge that retires the word.

// File: rtl/wocmd_pkg.sv
package wocmd_pkg;

    localparam int unsigned BUS_AW      = 8;
    localparam int unsigned BUS_DW      = 32;
    localparam int unsigned STORE_DEPTH = 8;

    // offsets of the three mapped locations
    localparam logic [7:0] OFS_CMD  = 8'h10;
    localparam logic [7:0] OFS_DATA = 8'h14;
    localparam logic [7:0] OFS_STAT = 8'h18;

    // command bit positions
    localparam int unsigned CMD_W     = 3;
    localparam int unsigned BIT_START = 0;
    localparam int unsigned BIT_ABORT = 1;
    localparam int unsigned BIT_FLUSH = 2;

    // status word layout
    localparam int unsigned STAT_RUN     = 0;
    localparam int unsigned STAT_OVF     = 1;
    localparam int unsigned STAT_CNT_LSB = 8;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_CMD,
        RGN_DATA,
        RGN_STAT
    } region_e;

    typedef struct packed {
        logic flush;
        logic abort;
        logic start;
    } act_t;

    function automatic logic is_wo(input region_e r);
        return (r == RGN_CMD) || (r == RGN_DATA);
    endfunction

endpackage

// File: rtl/wocmd_apb_dec.sv
module wocmd_apb_dec
    import wocmd_pkg::*;
#(
    parameter int unsigned ADDR_W    = BUS_AW,
    parameter int unsigned DATA_W    = BUS_DW,
    parameter int unsigned CNT_W     = 4,
    parameter bit          STRICT_RD = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [CMD_W-1:0]  cmd_bits,
    input  logic              run,
    input  logic              ovf,
    input  logic [CNT_W-1:0]  cnt,
    output act_t              act,
    output logic              push,
    output logic [DATA_W-1:0] prdata,
    output logic              pslverr
);

    region_e           rgn;
    logic              access, wr_en, rd_en;
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        if      (paddr == ADDR_W'(OFS_CMD))  rgn = RGN_CMD;
        else if (paddr == ADDR_W'(OFS_DATA)) rgn = RGN_DATA;
        else if (paddr == ADDR_W'(OFS_STAT)) rgn = RGN_STAT;
        else                                 rgn = RGN_NONE;
    end

    assign access = psel & penable;
    assign wr_en  = access & pwrite;
    assign rd_en  = access & ~pwrite;

    // strobes: write event of the command offset AND the written bit
    always_comb begin
        act.start = wr_en && (rgn == RGN_CMD) && cmd_bits[BIT_START];
        act.abort = wr_en && (rgn == RGN_CMD) && cmd_bits[BIT_ABORT];
        act.flush = wr_en && (rgn == RGN_CMD) && cmd_bits[BIT_FLUSH];
        push      = wr_en && (rgn == RGN_DATA);
    end

    always_comb begin
        stat_word                           = '0;
        stat_word[STAT_RUN]                 = run;
        stat_word[STAT_OVF]                 = ovf;
        stat_word[STAT_CNT_LSB +: CNT_W]    = cnt;
    end

    always_comb begin
        prdata  = '0;
        pslverr = 1'b0;
        if (rd_en && (rgn == RGN_STAT)) prdata = stat_word;
        if (access && (rgn == RGN_NONE)) pslverr = 1'b1;
        if (STRICT_RD && rd_en && is_wo(rgn)) pslverr = 1'b1;
    end

    AST_READ_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && !pwrite) |-> (act == '0 && !push)); // R6

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        act.start |=> !act.start); // R3

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && !pwrite &&
         (paddr == ADDR_W'(OFS_CMD) || paddr == ADDR_W'(OFS_DATA))) |-> (prdata == '0)); // R9

    generate
        if (STRICT_RD) begin : g_strict
            AST_STRICT_ERR: assert property (@(posedge clk) disable iff (rst)
                (psel && penable && !pwrite &&
                 (paddr == ADDR_W'(OFS_CMD) || paddr == ADDR_W'(OFS_DATA))) |-> pslverr); // R9
        end else begin : g_zero
            AST_ZERO_NO_ERR: assert property (@(posedge clk) disable iff (rst)
                (psel && penable && !pwrite &&
                 (paddr == ADDR_W'(OFS_CMD) || paddr == ADDR_W'(OFS_DATA))) |-> !pslverr); // R9
        end
    endgenerate

endmodule

// File: rtl/wocmd_engine.sv
module wocmd_engine
    import wocmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  act_t act,
    output logic run
);

    always_ff @(posedge clk) begin
        if (rst)            run <= 1'b0;
        else if (act.abort) run <= 1'b0;
        else if (act.start) run <= 1'b1;
    end

    AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> $past(act.start)); // R3

    AST_ABORT_WINS: assert property (@(posedge clk) disable iff (rst)
        act.abort |=> !run); // R4

endmodule

// File: rtl/wocmd_store.sv
module wocmd_store #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flush,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              valid,
    output logic [CNT_W-1:0]  count,
    output logic              ovf
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic              full, do_pop, do_push, drop;

    assign full    = (count == CNT_W'(DEPTH));
    assign valid   = (count != '0);
    assign do_pop  = pop && valid && !flush;
    assign do_push = push && (!full || do_pop) && !flush;
    assign drop    = push && full && !do_pop;
    assign rdata   = mem[rptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= nxt(wptr);
            if (do_pop)  rptr <= nxt(rptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       ovf <= 1'b0;
        else if (drop) ovf <= 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R8

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> ($stable(count) && ovf)); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf); // R8

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0)); // R5

endmodule

// File: rtl/wocmd_regblk.sv
module wocmd_regblk
    import wocmd_pkg::*;
#(
    parameter int unsigned ADDR_W    = BUS_AW,
    parameter int unsigned DATA_W    = BUS_DW,
    parameter int unsigned DEPTH     = STORE_DEPTH,
    parameter bit          STRICT_RD = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              start_pulse,
    output logic              abort_pulse,
    output logic              flush_pulse,
    output logic              engine_run,
    output logic [DATA_W-1:0] key_data,
    output logic              key_valid,
    input  logic              key_pop,
    output logic              store_overflow
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    act_t             act;
    logic             push;
    logic [CNT_W-1:0] cnt;

    assign pready = 1'b1;

    wocmd_apb_dec #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .STRICT_RD(STRICT_RD)
    ) u_dec (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .cmd_bits(pwdata[CMD_W-1:0]), .run(engine_run),
        .ovf(store_overflow), .cnt(cnt), .act(act), .push(push),
        .prdata(prdata), .pslverr(pslverr)
    );

    wocmd_engine u_eng (
        .clk(clk), .rst(rst), .act(act), .run(engine_run)
    );

    wocmd_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .push(push), .wdata(pwdata), .flush(act.flush),
        .pop(key_pop), .rdata(key_data), .valid(key_valid), .count(cnt),
        .ovf(store_overflow)
    );

    assign start_pulse = act.start;
    assign abort_pulse = act.abort;
    assign flush_pulse = act.flush;

    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        flush_pulse |=> !flush_pulse); // R5

endmodule

// File: tb/test_wocmd_regblk.sv
module test_wocmd_regblk;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, key_pop = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;

    logic [31:0] prdata, key_data, prdata_s, key_data_s;
    logic        pready, pslverr, start_pulse, abort_pulse, flush_pulse;
    logic        engine_run, key_valid, store_overflow;
    logic        pready_s, pslverr_s, sp_s, ap_s, fp_s, run_s, kv_s, ovf_s;

    int          checks = 0;
    int          fails  = 0;
    int          model_cnt = 0;
    logic [31:0] q[$];
    event        pop_ev;

    always #5 clk = ~clk;

    wocmd_regblk i_wocmd_regblk (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .start_pulse(start_pulse), .abort_pulse(abort_pulse),
        .flush_pulse(flush_pulse), .engine_run(engine_run), .key_data(key_data),
        .key_valid(key_valid), .key_pop(key_pop), .store_overflow(store_overflow)
    );

    wocmd_regblk #(.STRICT_RD(1'b1)) i_wocmd_regblk_strict (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_s), .pready(pready_s),
        .pslverr(pslverr_s), .start_pulse(sp_s), .abort_pulse(ap_s),
        .flush_pulse(fp_s), .engine_run(run_s), .key_data(key_data_s),
        .key_valid(kv_s), .key_pop(key_pop), .store_overflow(ovf_s)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] stat(input int run, input int ovf, input int cnt);
        return (32'(cnt) << 8) | (32'(ovf) << 1) | 32'(run);
    endfunction

    // one APB transfer; strobes, prdata and pslverr sampled mid access cycle
    task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic er, output logic er_s,
                       output logic [2:0] pl);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        #1;
        chk("R3", "no strobe in setup", {29'b0, flush_pulse, abort_pulse, start_pulse}, 32'h0);
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd = prdata; er = pslverr; er_s = pslverr_s;
        pl = {flush_pulse, abort_pulse, start_pulse};
        chk("R2", "pready", {31'b0, pready}, 32'h1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #1;
        chk("R3", "strobe gone after access", {29'b0, flush_pulse, abort_pulse, start_pulse}, 32'h0);
    endtask

    task automatic cmd(input logic [31:0] d, input string req, input logic [2:0] exp_pl);
        logic [31:0] rd; logic er, ers; logic [2:0] pl;
        bus(1'b1, 8'h10, d, rd, er, ers, pl);
        chk(req, "command strobes", {29'b0, pl}, {29'b0, exp_pl});
        chk(req, "command write error", {31'b0, er}, 32'h0);
        if (exp_pl[2]) model_cnt = 0;
        if (exp_pl[2]) q.delete();
    endtask

    task automatic push_word(input logic [31:0] d);
        logic [31:0] rd; logic er, ers; logic [2:0] pl;
        bus(1'b1, 8'h14, d, rd, er, ers, pl);
        chk("R7", "push strobes", {29'b0, pl}, 32'h0);
        chk("R7", "push error", {31'b0, er}, 32'h0);
        if (model_cnt < 8) begin
            q.push_back(d);
            model_cnt++;
        end
    endtask

    task automatic read_stat(input string req, input logic [31:0] exp);
        logic [31:0] rd; logic er, ers; logic [2:0] pl;
        bus(1'b0, 8'h18, 32'h0, rd, er, ers, pl);
        chk(req, "status word", rd, exp);
        chk(req, "status error", {31'b0, er}, 32'h0);
        chk("R6", "no strobe on read", {29'b0, pl}, 32'h0);
    endtask

    task automatic pop_word();
        @(negedge clk);
        key_pop = 1'b1;
        #1;
        -> pop_ev;
        @(negedge clk);
        key_pop = 1'b0;
        model_cnt--;
    endtask

    // scoreboard monitor
    always @(pop_ev) begin
        chk("R7", "valid at pop", {31'b0, key_valid}, 32'h1);
        if (q.size() == 0) chk("R7", "unexpected word", key_data, 32'hxxxxxxxx);
        else               chk("R7", "store head", key_data, q.pop_front());
    end

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..R11 actual=hang expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd; logic er, ers; logic [2:0] pl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        chk("R1", "run after reset", {31'b0, engine_run}, 32'h0);
        chk("R1", "valid after reset", {31'b0, key_valid}, 32'h0);
        chk("R1", "overflow after reset", {31'b0, store_overflow}, 32'h0);
        chk("R1", "idle prdata", prdata, 32'h0);
        chk("R1", "idle pslverr", {31'b0, pslverr}, 32'h0);
        read_stat("R1", stat(0, 0, 0));

        // R3 start
        cmd(32'h1, "R3", 3'b001);
        chk("R3", "run after start", {31'b0, engine_run}, 32'h1);

        // R6 zero write and read do nothing
        cmd(32'hFFFF_FFF8, "R6", 3'b000);
        chk("R6", "run kept after zero write", {31'b0, engine_run}, 32'h1);
        bus(1'b0, 8'h10, 32'h0, rd, er, ers, pl);
        chk("R6", "no strobe on command read", {29'b0, pl}, 32'h0);
        chk("R9", "command read data", rd, 32'h0);
        chk("R9", "zero policy error", {31'b0, er}, 32'h0);
        chk("R9", "strict policy error", {31'b0, ers}, 32'h1);
        chk("R6", "run kept after read", {31'b0, engine_run}, 32'h1);

        // R4 abort, then abort against start
        cmd(32'h2, "R4", 3'b010);
        chk("R4", "run after abort", {31'b0, engine_run}, 32'h0);
        cmd(32'h3, "R4", 3'b011);
        chk("R4", "abort beats start", {31'b0, engine_run}, 32'h0);

        // R7 push and drain in order
        push_word(32'hA5A5_0001);
        push_word(32'h1234_5678);
        push_word(32'hDEAD_BEEF);
        read_stat("R10", stat(0, 0, 3));
        bus(1'b0, 8'h14, 32'h0, rd, er, ers, pl);
        chk("R9", "key read hides data", rd, 32'h0);
        chk("R9", "key read zero policy", {31'b0, er}, 32'h0);
        chk("R9", "key read strict policy", {31'b0, ers}, 32'h1);
        chk("R9", "strict key read data", prdata_s, 32'h0);
        pop_word();
        pop_word();
        read_stat("R10", stat(0, 0, 1));

        // R5 flush
        cmd(32'h4, "R5", 3'b100);
        chk("R5", "store empty after flush", {31'b0, key_valid}, 32'h0);
        read_stat("R5", stat(0, 0, 0));

        // R5 combined start/abort/flush
        cmd(32'h1, "R3", 3'b001);
        push_word(32'h0000_0077);
        cmd(32'h7, "R5", 3'b111);
        chk("R5", "run low after combined", {31'b0, engine_run}, 32'h0);
        read_stat("R5", stat(0, 0, 0));

        // R8 fill past capacity
        for (int i = 0; i < 9; i++) push_word(32'hC000_0000 + 32'(i));
        chk("R8", "overflow flag", {31'b0, store_overflow}, 32'h1);
        read_stat("R8", stat(0, 1, 8));
        for (int i = 0; i < 8; i++) pop_word();
        chk("R8", "store drained", {31'b0, key_valid}, 32'h0);
        chk("R8", "overflow sticky", {31'b0, store_overflow}, 32'h1);

        // R10 status write ignored
        bus(1'b1, 8'h18, 32'hFFFF_FFFF, rd, er, ers, pl);
        chk("R10", "status write error", {31'b0, er}, 32'h0);
        chk("R10", "status write strobes", {29'b0, pl}, 32'h0);
        read_stat("R10", stat(0, 1, 0));

        // R11 unmapped
        bus(1'b1, 8'h20, 32'h7, rd, er, ers, pl);
        chk("R11", "unmapped write error", {31'b0, er}, 32'h1);
        chk("R11", "unmapped write strobes", {29'b0, pl}, 32'h0);
        bus(1'b0, 8'h11, 32'h0, rd, er, ers, pl);
        chk("R11", "unmapped read error", {31'b0, er}, 32'h1);
        read_stat("R11", stat(0, 1, 0));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule